// File: doc/BRIEF.md
# Serial stream pair selector

This block sits between ten pairs of serial links and a time-slot switch core that has only four serial ports in each direction. Link pairs 0 and 1 always connect to core ports 0 and 1. The other two core ports connect to two link pairs, called A and B, which are picked from pairs 2 to 9. Each chosen pair is routed in both directions: its receive line feeds the core, and the core's transmit line drives the pair's transmit output. With four 2.048 Mb/s streams in each direction, the core acts as a 128 by 128 channel non-blocking switch. Link transmit outputs that are not chosen stay at the idle level, logic high.

Software writes a new choice through a register write port. The block stages the written value and applies it only at the next frame pulse, so no stream changes its route partway through a frame. A control state machine tracks whether a staged value is waiting. It has two states. CFG_STABLE means nothing is waiting. CFG_PENDING means a staged value waits for a frame pulse. The transitions are STAGE (CFG_STABLE to CFG_PENDING on a write), APPLY (CFG_PENDING to CFG_STABLE on a frame pulse with no write), RESTAGE (CFG_PENDING stays CFG_PENDING on a write) and WAIT (each state holds otherwise). If A and B name the same pair, the block flags a conflict. The pair's input then feeds both core ports, and its output is driven from port A.

Top module: `stream_pair_sel`

## Requirements
- R1: Core receive ports 0 and 1 always equal link receive lines 0 and 1. Link transmit lines 0 and 1 always equal core transmit ports 0 and 1.
- R2: With active codes A and B, core receive port 2 equals link receive line A+2 and core receive port 3 equals link receive line B+2.
- R3: Link transmit line A+2 equals core transmit port 2. Link transmit line B+2 equals core transmit port 3, unless B equals A.
- R4: A write through the register port does not change any route until a frame pulse samples the staged value. The route changes from the cycle after that pulse.
- R5: When several writes occur before one frame pulse, the pulse applies the last of them.
- R6: Every link transmit line among 2 to 9 that is neither A+2 nor B+2 is held at logic high.
- R7: When A equals B, sel_conflict is 1, both core ports 2 and 3 carry link receive line A+2, and link transmit line A+2 follows core transmit port 2. Otherwise sel_conflict is 0.
- R8: A write in the same cycle as a frame pulse, made while nothing is staged, is not applied by that pulse. It is applied by the next frame pulse.
- R9: The register word carries code A in bits 2:0 and code B in bits 5:3. A code c selects link pair c+2. After reset, A is 0 (pair 2), B is 1 (pair 3) and sel_conflict is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 4.096 MHz in service |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_pulse | input | 1 | One-cycle frame start marker; applies a staged selection |
| cfg_we | input | 1 | Write strobe for the selection register |
| cfg_wdata | input | 6 | Selection word: code A in bits 2:0, code B in bits 5:3 |
| link_rx | input | 10 | Serial receive lines of the ten link pairs |
| link_tx | output | 10 | Serial transmit lines of the ten link pairs |
| core_rx | output | 4 | Serial lines into the switch core |
| core_tx | input | 4 | Serial lines out of the switch core |
| sel_conflict | output | 1 | High while A and B name the same pair |

## Verification
The assertions check the following on every cycle: the hard-wired pairs, routing into core ports 2 and 3 from the active codes, the count of idle-high transmit lines, the conflict signalling, and that the active selection stays unchanged in any cycle without a frame pulse. Only the bench scenarios show the write ordering. That covers the delay from a write to its frame pulse, the rule that the last staged write wins, and deferral of a write that lands on a pulse. The bench checks these by driving distinct one-hot and mixed bit patterns through every route.

// File: rtl/sps_pkg.sv
package sps_pkg;
    typedef enum logic [0:0] {
        CFG_STABLE  = 1'b0,
        CFG_PENDING = 1'b1
    } cfg_state_e;
endpackage

// File: rtl/sps_cfg_fsm.sv
module sps_cfg_fsm
    import sps_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_pulse,
    input  logic             cfg_we,
    input  logic [2*SEL_W-1:0] cfg_wdata,
    output logic [SEL_W-1:0] act_a,
    output logic [SEL_W-1:0] act_b
);
    localparam logic [SEL_W-1:0] RST_A = SEL_W'(0);
    localparam logic [SEL_W-1:0] RST_B = SEL_W'(1);

    cfg_state_e state_q, state_d;
    logic [2*SEL_W-1:0] staged_q;
    logic do_stage, do_apply;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_STABLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_STABLE:  if (cfg_we) state_d = CFG_PENDING;                     // STAGE
            CFG_PENDING: if (frame_pulse && !cfg_we) state_d = CFG_STABLE;      // APPLY
            default:     state_d = CFG_STABLE;
        endcase
    end

    // state outputs
    always_comb begin
        do_stage = cfg_we;
        do_apply = 1'b0;
        unique case (state_q)
            CFG_STABLE:  do_apply = 1'b0;
            CFG_PENDING: do_apply = frame_pulse;
            default:     do_apply = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            staged_q <= {RST_B, RST_A};
            act_a    <= RST_A;
            act_b    <= RST_B;
        end else begin
            if (do_stage) staged_q <= cfg_wdata;
            if (do_apply) begin
                act_a <= staged_q[SEL_W-1:0];
                act_b <= staged_q[2*SEL_W-1:SEL_W];
            end
        end
    end
endmodule

// File: rtl/sps_in_mux.sv
module sps_in_mux #(
    parameter int NUM_PAIRS   = 10,
    parameter int FIXED_PAIRS = 2,
    parameter int SEL_W       = 3,
    localparam int CAND       = NUM_PAIRS - FIXED_PAIRS,
    localparam int CORE_PORTS = FIXED_PAIRS + 2
) (
    input  logic [NUM_PAIRS-1:0]  link_rx,
    input  logic [SEL_W-1:0]      act_a,
    input  logic [SEL_W-1:0]      act_b,
    output logic [CORE_PORTS-1:0] core_rx
);
    for (genvar f = 0; f < FIXED_PAIRS; f++) begin : g_fixed
        assign core_rx[f] = link_rx[f];
    end

    logic pick_a, pick_b;
    always_comb begin
        pick_a = 1'b1;
        pick_b = 1'b1;
        for (int i = 0; i < CAND; i++) begin
            if (act_a == SEL_W'(i)) pick_a = link_rx[FIXED_PAIRS+i];
            if (act_b == SEL_W'(i)) pick_b = link_rx[FIXED_PAIRS+i];
        end
    end

    assign core_rx[FIXED_PAIRS]   = pick_a;
    assign core_rx[FIXED_PAIRS+1] = pick_b;
endmodule

// File: rtl/sps_out_mux.sv
module sps_out_mux #(
    parameter int NUM_PAIRS   = 10,
    parameter int FIXED_PAIRS = 2,
    parameter int SEL_W       = 3,
    parameter logic IDLE_LVL  = 1'b1,
    localparam int CAND       = NUM_PAIRS - FIXED_PAIRS,
    localparam int CORE_PORTS = FIXED_PAIRS + 2
) (
    input  logic [CORE_PORTS-1:0] core_tx,
    input  logic [SEL_W-1:0]      act_a,
    input  logic [SEL_W-1:0]      act_b,
    output logic [NUM_PAIRS-1:0]  link_tx
);
    for (genvar f = 0; f < FIXED_PAIRS; f++) begin : g_fixed
        assign link_tx[f] = core_tx[f];
    end

    for (genvar c = 0; c < CAND; c++) begin : g_cand
        logic hit_a, hit_b;
        assign hit_a = (act_a == SEL_W'(c));
        assign hit_b = (act_b == SEL_W'(c));
        // port A takes precedence when both codes match
        assign link_tx[FIXED_PAIRS+c] = hit_a ? core_tx[FIXED_PAIRS]
                                      : hit_b ? core_tx[FIXED_PAIRS+1]
                                      : IDLE_LVL;
    end
endmodule

// File: rtl/stream_pair_sel.sv
module stream_pair_sel #(
    parameter int NUM_PAIRS   = 10,
    parameter int FIXED_PAIRS = 2,
    localparam int CAND       = NUM_PAIRS - FIXED_PAIRS,
    localparam int SEL_W      = $clog2(CAND),
    localparam int CORE_PORTS = FIXED_PAIRS + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_pulse,
    input  logic                  cfg_we,
    input  logic [2*SEL_W-1:0]    cfg_wdata,
    input  logic [NUM_PAIRS-1:0]  link_rx,
    output logic [NUM_PAIRS-1:0]  link_tx,
    output logic [CORE_PORTS-1:0] core_rx,
    input  logic [CORE_PORTS-1:0] core_tx,
    output logic                  sel_conflict
);
    logic [SEL_W-1:0] act_a, act_b;

    sps_cfg_fsm #(.SEL_W(SEL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .act_a(act_a), .act_b(act_b)
    );

    sps_in_mux #(.NUM_PAIRS(NUM_PAIRS), .FIXED_PAIRS(FIXED_PAIRS), .SEL_W(SEL_W)) u_in (
        .link_rx(link_rx), .act_a(act_a), .act_b(act_b), .core_rx(core_rx)
    );

    sps_out_mux #(.NUM_PAIRS(NUM_PAIRS), .FIXED_PAIRS(FIXED_PAIRS), .SEL_W(SEL_W),
                  .IDLE_LVL(1'b1)) u_out (
        .core_tx(core_tx), .act_a(act_a), .act_b(act_b), .link_tx(link_tx)
    );

    assign sel_conflict = (act_a == act_b);
endmodule

// File: rtl/sps_checker.sv
module sps_checker #(
    parameter int NUM_PAIRS   = 10,
    parameter int FIXED_PAIRS = 2,
    parameter int SEL_W       = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   frame_pulse,
    input logic [NUM_PAIRS-1:0]   link_rx,
    input logic [NUM_PAIRS-1:0]   link_tx,
    input logic [FIXED_PAIRS+1:0] core_rx,
    input logic [FIXED_PAIRS+1:0] core_tx,
    input logic                   sel_conflict,
    input logic [SEL_W-1:0]       act_a,
    input logic [SEL_W-1:0]       act_b
);
    localparam int CAND = NUM_PAIRS - FIXED_PAIRS;

    a_r1_fixed_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rx[FIXED_PAIRS-1:0] == link_rx[FIXED_PAIRS-1:0]) &&
        (link_tx[FIXED_PAIRS-1:0] == core_tx[FIXED_PAIRS-1:0]));

    a_r2_route_a: assert property (@(posedge clk) disable iff (!rst_n)
        core_rx[FIXED_PAIRS] == link_rx[FIXED_PAIRS + int'(act_a)]);

    a_r2_route_b: assert property (@(posedge clk) disable iff (!rst_n)
        core_rx[FIXED_PAIRS+1] == link_rx[FIXED_PAIRS + int'(act_b)]);

    a_r4_hold_between_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_pulse |=> $stable({act_a, act_b}));

    a_r6_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
        (core_tx[FIXED_PAIRS+1:FIXED_PAIRS] == 2'b00) |->
        ($countones(link_tx[NUM_PAIRS-1:FIXED_PAIRS]) == (sel_conflict ? CAND-1 : CAND-2)));

    a_r7_conflict_dup: assert property (@(posedge clk) disable iff (!rst_n)
        sel_conflict |-> (core_rx[FIXED_PAIRS] == core_rx[FIXED_PAIRS+1]) &&
                         (link_tx[FIXED_PAIRS + int'(act_a)] == core_tx[FIXED_PAIRS]));
endmodule

bind stream_pair_sel sps_checker #(
    .NUM_PAIRS(NUM_PAIRS), .FIXED_PAIRS(FIXED_PAIRS), .SEL_W(SEL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
    .link_rx(link_rx), .link_tx(link_tx), .core_rx(core_rx), .core_tx(core_tx),
    .sel_conflict(sel_conflict), .act_a(act_a), .act_b(act_b)
);

// File: tb/stream_pair_sel_bench.sv
`timescale 1ns/1ps
module stream_pair_sel_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_pulse = 1'b0;
    logic cfg_we = 1'b0;
    logic [5:0] cfg_wdata = '0;
    logic [9:0] link_rx = '0;
    logic [9:0] link_tx;
    logic [3:0] core_rx;
    logic [3:0] core_tx = '0;
    logic sel_conflict;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    stream_pair_sel u_stream_pair_sel (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .link_rx(link_rx), .link_tx(link_tx),
        .core_rx(core_rx), .core_tx(core_tx),
        .sel_conflict(sel_conflict)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // compares all routes against the model codes a, b over several patterns
    task automatic check_map(input string tag, input int a, input int b);
        logic [9:0] rx_pat [4] = '{10'h3FF & 10'b1010110011, 10'h001 << (a + 2), 10'h001 << (b + 2), 10'h2AA};
        logic [3:0] tx_pat [4] = '{4'b0101, 4'b1010, 4'b0011, 4'b1100};
        for (int p = 0; p < 4; p++) begin
            logic [3:0] exp_core;
            logic [9:0] exp_link;
            @(negedge clk);
            link_rx = rx_pat[p];
            core_tx = tx_pat[p];
            #1;
            exp_core = {link_rx[b + 2], link_rx[a + 2], link_rx[1], link_rx[0]};
            exp_link = '1;
            exp_link[0] = core_tx[0];
            exp_link[1] = core_tx[1];
            if (b != a) exp_link[b + 2] = core_tx[3];
            exp_link[a + 2] = core_tx[2];
            check(core_rx == exp_core, {tag, " core_rx (R1 R2)"}, core_rx, exp_core);
            check(link_tx == exp_link, {tag, " link_tx (R1 R3 R6)"}, link_tx, exp_link);
            check(sel_conflict == (a == b), {tag, " sel_conflict (R7)"}, sel_conflict, (a == b));
        end
    endtask

    task automatic write_sel(input int a, input int b, input bit with_pulse);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = {3'(b), 3'(a)};
        frame_pulse = with_pulse;
        @(negedge clk);
        cfg_we = 1'b0;
        frame_pulse = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk);
        frame_pulse = 1'b1;
        @(negedge clk);
        frame_pulse = 1'b0;
    endtask

    task automatic t_reset();
        check_map("R9 reset", 0, 1);
    endtask

    task automatic t_route();
        write_sel(5, 2, 1'b0);
        pulse();
        check_map("R2 R3 route 5/2", 5, 2);
        write_sel(7, 0, 1'b0);
        pulse();
        check_map("R2 R3 route 7/0", 7, 0);
    endtask

    task automatic t_deferred();
        write_sel(3, 6, 1'b0);
        repeat (5) @(negedge clk);
        check_map("R4 before pulse", 7, 0);
        pulse();
        check_map("R4 after pulse", 3, 6);
    endtask

    task automatic t_last_wins();
        write_sel(1, 4, 1'b0);
        write_sel(6, 2, 1'b0);
        write_sel(4, 7, 1'b0);
        pulse();
        check_map("R5 last write", 4, 7);
    endtask

    task automatic t_conflict();
        write_sel(3, 3, 1'b0);
        pulse();
        check_map("R7 conflict", 3, 3);
        write_sel(0, 5, 1'b0);
        pulse();
        check_map("R7 cleared", 0, 5);
    endtask

    task automatic t_coincide();
        write_sel(2, 6, 1'b1);
        check_map("R8 not on same pulse", 0, 5);
        pulse();
        check_map("R8 next pulse", 2, 6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_route();
        t_deferred();
        t_last_wins();
        t_conflict();
        t_coincide();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule